// File: doc/BRIEF.md
# Dual-Width Integer ALU with Status Flags

This block is the integer arithmetic-logic stage of a small processor datapath. It takes two operands and a 3-bit opcode and computes a result in one combinational pass, either over the full word or over the low half-word. The choice between the two is made per operation by a width select input. Eight operations are supported: plain add, add using the stored carry, plain subtract, subtract using the stored carry as a borrow, bitwise AND, OR and XOR, and a compare. The compare subtracts only to produce flags.

Six condition flags are produced next to the result. They are always judged at the selected width. The exception is parity, which looks only at the low byte in both widths. A flag register captures the fresh flags on a clock edge when the load enable is high. Its carry bit is fed back as the carry or borrow input of the next add-with-carry or subtract-with-borrow, which lets software chain operations across several words.

Top module: `dwa_alu`

## Requirements
- R1: With `wide_i`=1 the operation uses all 16 bits. With `wide_i`=0 it uses only bits 7:0 of each operand, ignores the upper operand bytes, and drives `result_o[15:8]` to zero.
- R2: Opcodes 0 ADD, 1 ADC, 2 SUB and 3 SBB give a+b, a+b+C, a-b and a-b-C, each modulo 2^W, where W is the selected width and C is bit 0 of `flags_q_o`. ADD and SUB ignore C.
- R3: Opcodes 4 AND, 5 OR and 6 XOR give the bitwise result and force the carry, auxiliary and overflow flags to 0.
- R4: Opcode 7 CMP produces the same result and flags as SUB and drives `writeback_o` low. Every other opcode drives `writeback_o` high.
- R5: Flag vector layout: bit 0 carry, bit 1 parity, bit 2 auxiliary, bit 3 zero, bit 4 sign, bit 5 overflow. Carry is 1 on a carry out of bit W-1 for additions, and on a borrow for subtractions (a < b+C, unsigned).
- R6: Parity is 1 when `result_o[7:0]` holds an even number of ones, in both widths.
- R7: Auxiliary is 1 on a carry from bit 3 into bit 4 for additions, and on a borrow out of the low nibble for subtractions.
- R8: Zero is 1 exactly when the W-bit result is all zeros. Sign equals result bit W-1.
- R9: Overflow is 1 when the signed two's-complement result at width W falls outside the W-bit signed range.
- R10: `flags_q_o` resets to 0. It loads `flags_o` at a rising clock edge when `flag_en_i`=1 and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| op_i | input | 3 | Operation code |
| wide_i | input | 1 | 1 selects the 16-bit width, 0 selects the 8-bit width |
| flag_en_i | input | 1 | Load enable for the flag register |
| result_o | output | 16 | Operation result |
| flags_o | output | 6 | Flags of the current operation |
| writeback_o | output | 1 | High when the result is meant to be stored |
| flags_q_o | output | 6 | Registered flags |

## Verification
The bench builds the block with its default 16-bit word, which gives an 8-bit narrow mode. That makes the narrow path small enough to sweep densely: a stepped grid over both operand bytes is run for every opcode and for both values of the stored carry. This grid reaches every nibble-carry and sign-boundary pattern the flags depend on. The wide mode is covered by pseudo-random operand pairs plus hand-picked edges: signed wrap points, an equal-operand compare, and parity that must ignore the upper byte.

// File: rtl/dwa_pkg.sv
package dwa_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBB = 3'd3,
    OP_AND = 3'd4,
    OP_OR  = 3'd5,
    OP_XOR = 3'd6,
    OP_CMP = 3'd7
  } dwa_op_e;

  // bit 0 is the carry, bit 5 the overflow
  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic cry;
  } dwa_flags_t;

  function automatic logic is_subtract(input dwa_op_e op);
    return (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
  endfunction

  function automatic logic uses_carry(input dwa_op_e op);
    return (op == OP_ADC) || (op == OP_SBB);
  endfunction

  function automatic logic is_bitwise(input dwa_op_e op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  endfunction

endpackage

// File: rtl/dwa_addsub.sv
module dwa_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cry,
  output logic         aux,
  output logic         ovf
);
  logic [W-1:0] b_eff;
  logic         c_eff;
  logic         c_out;
  logic         c_top;
  logic         c_nib;

  assign b_eff = sub ? ~b : b;
  assign c_eff = sub ? ~cin : cin;
  assign {c_out, sum} = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};

  // carries into the top bit and into bit 4, recovered from the sum bits
  assign c_top = sum[W-1] ^ a[W-1] ^ b_eff[W-1];
  assign c_nib = sum[4] ^ a[4] ^ b_eff[4];

  assign cry = c_out ^ sub;
  assign aux = c_nib ^ sub;
  assign ovf = c_out ^ c_top;
endmodule

// File: rtl/dwa_flag_gen.sv
module dwa_flag_gen
  import dwa_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] result,
  input  logic              wide,
  input  logic              bitwise,
  input  logic              a_cry,
  input  logic              a_aux,
  input  logic              a_ovf,
  output dwa_flags_t        flags
);
  localparam int HALF_W = DATA_W / 2;

  always_comb begin
    flags.cry = bitwise ? 1'b0 : a_cry;
    flags.aux = bitwise ? 1'b0 : a_aux;
    flags.ovf = bitwise ? 1'b0 : a_ovf;
    flags.par = ~^result[7:0];
    flags.sgn = wide ? result[DATA_W-1] : result[HALF_W-1];
    flags.zro = wide ? (result == '0) : (result[HALF_W-1:0] == '0);
  end
endmodule

// File: rtl/dwa_flag_reg.sv
module dwa_flag_reg
  import dwa_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  dwa_flags_t d,
  output dwa_flags_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/dwa_alu.sv
module dwa_alu
  import dwa_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [2:0]        op_i,
  input  logic              wide_i,
  input  logic              flag_en_i,
  output logic [DATA_W-1:0] result_o,
  output logic [5:0]        flags_o,
  output logic              writeback_o,
  output logic [5:0]        flags_q_o
);
  localparam int HALF_W = DATA_W / 2;
  localparam int PAD_W  = DATA_W - HALF_W;

  dwa_op_e    op;
  dwa_flags_t f_new;
  dwa_flags_t f_q;
  logic       sub, bitwise, cin;

  assign op      = dwa_op_e'(op_i);
  assign sub     = is_subtract(op);
  assign bitwise = is_bitwise(op);
  assign cin     = uses_carry(op) & f_q.cry;

  logic [HALF_W-1:0] n_sum;
  logic [DATA_W-1:0] w_sum;
  logic n_cry, n_aux, n_ovf, w_cry, w_aux, w_ovf;

  dwa_addsub #(.W(HALF_W)) u_narrow (
    .a(a_i[HALF_W-1:0]), .b(b_i[HALF_W-1:0]), .sub(sub), .cin(cin),
    .sum(n_sum), .cry(n_cry), .aux(n_aux), .ovf(n_ovf)
  );

  dwa_addsub #(.W(DATA_W)) u_wide (
    .a(a_i), .b(b_i), .sub(sub), .cin(cin),
    .sum(w_sum), .cry(w_cry), .aux(w_aux), .ovf(w_ovf)
  );

  logic [DATA_W-1:0] bit_full, bit_res, ari_res, res;

  always_comb begin
    case (op)
      OP_AND:  bit_full = a_i & b_i;
      OP_OR:   bit_full = a_i | b_i;
      default: bit_full = a_i ^ b_i;
    endcase
  end

  assign bit_res = wide_i ? bit_full : {{PAD_W{1'b0}}, bit_full[HALF_W-1:0]};
  assign ari_res = wide_i ? w_sum    : {{PAD_W{1'b0}}, n_sum};
  assign res     = bitwise ? bit_res : ari_res;

  dwa_flag_gen #(.DATA_W(DATA_W)) u_flags (
    .result(res), .wide(wide_i), .bitwise(bitwise),
    .a_cry(wide_i ? w_cry : n_cry),
    .a_aux(wide_i ? w_aux : n_aux),
    .a_ovf(wide_i ? w_ovf : n_ovf),
    .flags(f_new)
  );

  dwa_flag_reg u_freg (
    .clk(clk), .rst_n(rst_n), .load(flag_en_i), .d(f_new), .q(f_q)
  );

  assign result_o    = res;
  assign flags_o     = f_new;
  assign flags_q_o   = f_q;
  assign writeback_o = (op != OP_CMP);
endmodule

// File: rtl/dwa_alu_chk.sv
module dwa_alu_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        op_i,
  input logic              wide_i,
  input logic              flag_en_i,
  input logic [DATA_W-1:0] result_o,
  input logic [5:0]        flags_o,
  input logic              writeback_o,
  input logic [5:0]        flags_q_o
);
  localparam int HALF_W = DATA_W / 2;

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_i |-> result_o[DATA_W-1:HALF_W] == '0); // R1

  AST_BITWISE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i inside {3'd4, 3'd5, 3'd6}) |-> (flags_o[0] == 1'b0 && flags_o[2] == 1'b0 && flags_o[5] == 1'b0)); // R3

  AST_CMP_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd7) |-> !writeback_o); // R4

  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    flags_o[3] == (result_o == '0)); // R8

  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    flag_en_i |=> flags_q_o == $past(flags_o)); // R10

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_en_i |=> $stable(flags_q_o)); // R10
endmodule

bind dwa_alu dwa_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_i(op_i), .wide_i(wide_i), .flag_en_i(flag_en_i),
  .result_o(result_o), .flags_o(flags_o), .writeback_o(writeback_o), .flags_q_o(flags_q_o)
);

// File: tb/dwa_alu_tb_top.sv
module dwa_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] a_i = '0, b_i = '0;
  logic [2:0]  op_i = '0;
  logic        wide_i = 1'b0, flag_en_i = 1'b0;
  logic [15:0] result_o;
  logic [5:0]  flags_o, flags_q_o;
  logic        writeback_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  dwa_alu dut_i (
    .clk(clk), .rst_n(rst_n), .a_i(a_i), .b_i(b_i), .op_i(op_i), .wide_i(wide_i),
    .flag_en_i(flag_en_i), .result_o(result_o), .flags_o(flags_o),
    .writeback_o(writeback_o), .flags_q_o(flags_q_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s op=%0d wide=%0b a=%h b=%h actual=%h expected=%h",
               req, op_i, wide_i, a_i, b_i, act, exp);
    end
  endtask

  // independent reference written from the requirements
  task automatic model(input int op, input bit wide, input int a_in, input int b_in,
                       input int c_in, output int res, output int fl, output int wb);
    int w = wide ? 16 : 8;
    int m = (1 << w) - 1;
    int a = a_in & m, b = b_in & m;
    int c = (op == 1 || op == 3) ? c_in : 0;
    int sa = (a >= (1 << (w-1))) ? a - (1 << w) : a;
    int sb = (b >= (1 << (w-1))) ? b - (1 << w) : b;
    int smax = (1 << (w-1)) - 1, smin = -(1 << (w-1));
    int cf = 0, af = 0, of = 0, pf, zf, sf, ones, r;
    if (op <= 1) begin
      r  = a + b + c;
      cf = (r > m) ? 1 : 0;
      af = ((a & 15) + (b & 15) + c > 15) ? 1 : 0;
      of = (sa + sb + c > smax || sa + sb + c < smin) ? 1 : 0;
    end else if (op == 2 || op == 3 || op == 7) begin
      r  = a - b - c;
      cf = (a < b + c) ? 1 : 0;
      af = ((a & 15) < (b & 15) + c) ? 1 : 0;
      of = (sa - sb - c > smax || sa - sb - c < smin) ? 1 : 0;
    end else if (op == 4) r = a & b;
    else if (op == 5)     r = a | b;
    else                  r = a ^ b;
    res = r & m;
    ones = 0;
    for (int i = 0; i < 8; i++) ones += (res >> i) & 1;
    pf = (ones % 2 == 0) ? 1 : 0;
    zf = (res == 0) ? 1 : 0;
    sf = (res >> (w-1)) & 1;
    fl = cf | (pf << 1) | (af << 2) | (zf << 3) | (sf << 4) | (of << 5);
    wb = (op == 7) ? 0 : 1;
  endtask

  task automatic apply(input int op, input bit wide, input int a, input int b, input int cq);
    int er, ef, ew;
    op_i = op[2:0]; wide_i = wide; a_i = a[15:0]; b_i = b[15:0];
    #1;
    model(op, wide, a, b, cq, er, ef, ew);
    if (op == 7)      chk("R4 result", int'(result_o), er);
    else if (op >= 4) chk("R3 result", int'(result_o), er);
    else              chk("R2 result", int'(result_o), er);
    chk("R1/R5/R6/R7/R8/R9 flags", int'(flags_o), ef);
    chk("R4 writeback", int'(writeback_o), ew);
  endtask

  task automatic set_carry(input bit c);
    @(negedge clk);
    op_i = c ? 3'd0 : 3'd4; wide_i = 1'b0; a_i = 16'h00FF; b_i = 16'h0001; flag_en_i = 1'b1;
    @(negedge clk);
    flag_en_i = 1'b0;
    chk("R10 carry load", int'(flags_q_o[0]), int'(c));
  endtask

  initial begin
    #(20 * 190000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed = 32'h1234_5678;
    #35;
    chk("R10 reset", int'(flags_q_o), 0);
    rst_n = 1'b1;

    // R10: load on enable, then hold while inputs change
    @(negedge clk);
    op_i = 3'd0; wide_i = 1'b0; a_i = 16'h00FF; b_i = 16'h0001; flag_en_i = 1'b1;
    @(negedge clk);
    flag_en_i = 1'b0;
    chk("R10 load", int'(flags_q_o), 6'h0F);
    op_i = 3'd4; a_i = 16'h1234; b_i = 16'h00F0;
    @(negedge clk);
    @(negedge clk);
    chk("R10 hold", int'(flags_q_o), 6'h0F);

    for (int cq = 0; cq < 2; cq++) begin
      set_carry(cq[0]);
      for (int op = 0; op < 8; op++) begin
        // R1: narrow grid, upper bytes filled with noise that must be ignored
        for (int a = 0; a < 256; a += 5)
          for (int b = 0; b < 256; b += 11)
            apply(op, 1'b0, a | (((a * 7) & 255) << 8), b | (((b * 13) & 255) << 8), cq);
        for (int k = 0; k < 600; k++) begin
          seed = seed * 1103515245 + 12345;
          apply(op, 1'b1, (seed >> 8) & 16'hFFFF, (seed >> 3) & 16'hFFFF, cq);
        end
      end
      // boundary cases
      apply(0, 1'b0, 8'h7F, 8'h01, cq);         // R9 narrow signed wrap
      apply(0, 1'b1, 16'h7FFF, 16'h0001, cq);   // R9 wide signed wrap
      apply(2, 1'b1, 16'h8000, 16'h0001, cq);   // R9 wide negative wrap
      apply(3, 1'b1, 16'h0000, 16'h0000, cq);   // R5 borrow with stored carry
      apply(1, 1'b1, 16'hFFFF, 16'h0000, cq);   // R5 carry from stored carry
      apply(7, 1'b1, 16'hABCD, 16'hABCD, cq);   // R4 equal compare, R8 zero
      apply(6, 1'b1, 16'hFF03, 16'h0000, cq);   // R6 parity from low byte only
      apply(0, 1'b1, 16'h000F, 16'h0001, cq);   // R7 nibble carry
      apply(2, 1'b0, 8'h10, 8'h01, cq);         // R7 nibble borrow
      apply(5, 1'b1, 16'h8000, 16'h0000, cq);   // R8 sign wide
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule